// File: doc/BRIEF.md
# Four-Way Exact Recency Tracker

This block keeps the exact use order of the four ways of one cache set. Each way holds a valid bit and a 2-bit age, where 0 means most recently used and 3 means least recently used among four valid ways. A lookup hit on a way makes that way the youngest. Every valid way that was younger than the hit way ages by one step, and every older way keeps its age. A fill request places a new line. It goes into the lowest-numbered empty way while the set has one. Once the set is full, it goes into the way whose age is 3. The filled way becomes the youngest, and every other valid way ages by one.

The way a fill will use is always visible on `victim_o`, so the surrounding cache controller can read it before it asserts the fill. Ages and valid bits are output for observation. Tag compare, data storage and the handling of several sets belong to the logic around this block.

Top module: `lru_age_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every valid bit and every age is cleared to 0.
- R2: While at least one way is invalid, `victim_o` names the lowest-numbered invalid way. A fill then sets that way's valid bit and its age to 0.
- R3: On a fill into a set that is not full, every other valid way's age increases by 1. Invalid ways keep age 0.
- R4: While all four ways are valid, `victim_o` names the way whose age is 3.
- R5: On a fill into a full set, the victim's age becomes 0, every other way's age increases by 1, and all ways stay valid.
- R6: On a hit to a valid way, that way's age becomes 0. Each valid way whose age was below the hit way's old age increases by 1. All other ages are unchanged.
- R7: A hit that names an invalid way changes no age and no valid bit.
- R8: When `hit_i` and `fill_i` are both high, only the hit is performed and the fill is ignored. This holds even when the hit names an invalid way.
- R9: The valid ways always hold distinct ages, and every invalid way holds age 0.
- R10: Ages and valid bits are registered and change only at a clock edge. `victim_o` is combinational from the registered state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 1 | Lookup hit strobe |
| hit_way_i | input | 2 | Way that hit |
| fill_i | input | 1 | Request to place a new line |
| victim_o | output | 2 | Way the next fill will use |
| ages_o | output | 8 | Age of way i at bits [2i+1:2i] |
| valid_o | output | 4 | Valid bit of way i at bit i |

## Verification
A hit or a fill presented before a rising edge shows up in `ages_o` and `valid_o` right after that edge. The bench therefore compares these outputs 1 ns after each rising edge. `victim_o` depends only on the stored state, so the bench checks it at the falling edge before the next stimulus is driven. A behavioural model in the bench advances by the same one-edge step, and the bench compares the design against it on every cycle. The stimulus is a directed sequence followed by random traffic.

// File: rtl/lru_age_pkg.sv
// Package: shared types for the recency tracker.
// Assumes: none.
package lru_age_pkg;
    typedef enum logic [1:0] {
        LRU_OP_IDLE = 2'd0,
        LRU_OP_HIT  = 2'd1,
        LRU_OP_FILL = 2'd2
    } lru_op_e;
endpackage

// File: rtl/lru_victim_pick.sv
// Module: chooses the way for the next fill.
// Picks the lowest-numbered invalid way. When every way is valid, it picks
// the way whose age is the maximum value.
// Assumes: the valid ways hold distinct ages.
module lru_victim_pick #(
    parameter int WAYS  = 4,
    parameter int AGE_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       valid_i,
    input  logic [WAYS*AGE_W-1:0] ages_i,
    output logic [AGE_W-1:0]      victim_o,
    output logic                  full_o
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    logic [AGE_W-1:0] free_way;
    logic [AGE_W-1:0] old_way;

    // Lowest-numbered invalid way; the downward scan lets lower indices win.
    always_comb begin
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_way = AGE_W'(i);
        end
    end

    // Way that holds the oldest age.
    always_comb begin
        old_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (ages_i[i*AGE_W +: AGE_W] == OLDEST) old_way = AGE_W'(i);
        end
    end

    // Final choice: the free way while one exists.
    always_comb begin
        full_o   = &valid_i;
        victim_o = full_o ? old_way : free_way;
    end
endmodule

// File: rtl/lru_age_cell.sv
// Module: valid bit and age register for one way.
// The way that is used gets age 0. A non-selected valid way ages on a fill,
// and on a hit only when it was younger than the hit way.
// Assumes: op_i is HIT only when the hit way is valid.
module lru_age_cell
    import lru_age_pkg::*;
#(
    parameter int AGE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lru_op_e          op_i,
    input  logic             sel_i,
    input  logic [AGE_W-1:0] ref_age_i,
    output logic [AGE_W-1:0] age_o,
    output logic             valid_o
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [AGE_W-1:0] age_q;
    logic             valid_q;
    logic             bump;

    // Decide whether this way ages by one this cycle.
    always_comb begin
        bump = 1'b0;
        if (valid_q && !sel_i && age_q != AGE_MAX) begin
            if (op_i == LRU_OP_FILL)                         bump = 1'b1;
            else if (op_i == LRU_OP_HIT && age_q < ref_age_i) bump = 1'b1;
        end
    end

    // Age and valid register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q   <= '0;
            valid_q <= 1'b0;
        end else if (sel_i && op_i != LRU_OP_IDLE) begin
            age_q <= '0;
            if (op_i == LRU_OP_FILL) valid_q <= 1'b1;
        end else if (bump) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign age_o   = age_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/lru_age_tracker.sv
// Module: exact recency tracker for one four-way set (top).
// Turns the hit and fill strobes into one operation on one target way, and
// sends that operation to the per-way age cells.
// Assumes: the hit way index is within range; the caller handles tags and data.
module lru_age_tracker
    import lru_age_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int AGE_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hit_i,
    input  logic [AGE_W-1:0]      hit_way_i,
    input  logic                  fill_i,
    output logic [AGE_W-1:0]      victim_o,
    output logic [WAYS*AGE_W-1:0] ages_o,
    output logic [WAYS-1:0]       valid_o
);
    lru_op_e          op;
    logic [AGE_W-1:0] tgt_way;
    logic [AGE_W-1:0] ref_age;
    logic             full;
    logic [AGE_W-1:0] age_q [WAYS];
    logic [WAYS-1:0]  valid_q;

    lru_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pick (
        .valid_i  (valid_q),
        .ages_i   (ages_o),
        .victim_o (victim_o),
        .full_o   (full)
    );

    // Operation decode: a hit wins; a hit on an invalid way does nothing.
    always_comb begin
        op      = LRU_OP_IDLE;
        tgt_way = victim_o;
        if (hit_i) begin
            tgt_way = hit_way_i;
            if (valid_q[hit_way_i]) op = LRU_OP_HIT;
        end else if (fill_i) begin
            op = LRU_OP_FILL;
        end
    end

    // Old age of the target way; the other cells compare against it.
    always_comb ref_age = age_q[tgt_way];

    for (genvar i = 0; i < WAYS; i++) begin : g_way
        lru_age_cell #(.AGE_W(AGE_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_i      (op),
            .sel_i     (tgt_way == AGE_W'(i)),
            .ref_age_i (ref_age),
            .age_o     (age_q[i]),
            .valid_o   (valid_q[i])
        );
        assign ages_o[i*AGE_W +: AGE_W] = age_q[i];
    end

    assign valid_o = valid_q;

    // Checking aids: the set of ages held by valid ways, and ages held by invalid ways.
    logic [WAYS-1:0] seen_ages;
    logic            stale_age;
    always_comb begin
        seen_ages = '0;
        stale_age = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (valid_q[i]) seen_ages[age_q[i]] = 1'b1;
            else if (age_q[i] != '0) stale_age = 1'b1;
        end
    end

    AST_DISTINCT_AGES: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen_ages) == $countones(valid_q)); // R9
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !stale_age); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0)); // R1
    AST_HIT_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && valid_q[hit_way_i]) |=> age_q[$past(hit_way_i)] == '0); // R6
    AST_FILL_PLACES: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !hit_i) |=> valid_q[$past(victim_o)] && age_q[$past(victim_o)] == '0); // R2
    AST_VALID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !valid_q[hit_way_i]) |=> $stable(valid_q) && $stable(ages_o)); // R7
    AST_FULL_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> age_q[victim_o] == AGE_W'(WAYS - 1)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i && !fill_i) |=> $stable(ages_o) && $stable(valid_q)); // R10
endmodule

// File: tb/lru_age_tracker_test.sv
// Bench: behavioural reference model, compared with the design on every cycle.
module lru_age_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_i = 1'b0;
    logic [1:0] hit_way_i = '0;
    logic       fill_i = 1'b0;
    logic [1:0] victim_o;
    logic [7:0] ages_o;
    logic [3:0] valid_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    int  m_age [4];
    bit  m_v   [4];

    always #5 clk = ~clk;

    lru_age_tracker uut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .hit_way_i(hit_way_i),
        .fill_i(fill_i), .victim_o(victim_o), .ages_o(ages_o), .valid_o(valid_o)
    );

    function automatic int m_victim();
        for (int i = 0; i < 4; i++) if (!m_v[i]) return i;
        for (int i = 0; i < 4; i++) if (m_age[i] == 3) return i;
        return 0;
    endfunction

    function automatic bit m_full();
        return m_v[0] && m_v[1] && m_v[2] && m_v[3];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare every way's age and valid bit with the model, then check R9 on the outputs.
    task automatic compare_state(input string req);
        for (int i = 0; i < 4; i++) begin
            check(int'(ages_o[2*i +: 2]) == m_age[i], req, int'(ages_o[2*i +: 2]), m_age[i]);
            check(valid_o[i] == m_v[i], req, int'(valid_o[i]), int'(m_v[i]));
        end
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++)
                if (valid_o[i] && valid_o[j])
                    check(ages_o[2*i +: 2] != ages_o[2*j +: 2], "R9 distinct",
                          int'(ages_o[2*i +: 2]), -1);
    endtask

    // One cycle: check the victim, drive the strobes, advance the model, check the state after the edge.
    task automatic step(input bit h, input int hw, input bit f);
        string req;
        @(negedge clk);
        check(int'(victim_o) == m_victim(), m_full() ? "R4 victim" : "R2 victim",
              int'(victim_o), m_victim());
        hit_i = h; hit_way_i = 2'(hw); fill_i = f;
        req = "R10 idle";
        if (h) begin
            if (m_v[hw]) begin
                int old = m_age[hw];
                for (int j = 0; j < 4; j++)
                    if (j != hw && m_v[j] && m_age[j] < old) m_age[j]++;
                m_age[hw] = 0;
                req = f ? "R8 hit over fill" : "R6 hit";
            end else begin
                req = f ? "R8 fill dropped" : "R7 invalid hit";
            end
        end else if (f) begin
            int vv = m_victim();
            req = m_full() ? "R5 full fill" : "R3 fill";
            for (int j = 0; j < 4; j++) if (j != vv && m_v[j]) m_age[j]++;
            m_age[vv] = 0;
            m_v[vv] = 1'b1;
        end
        @(posedge clk);
        #1;
        compare_state(req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_age[i] = 0; m_v[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #1;
        compare_state("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 1);             // R2: first fill goes to way 0
        step(1, 3, 0);             // R7: hit on the invalid way 3
        step(1, 2, 1);             // R8: invalid hit with fill; the fill is dropped
        step(0, 0, 1);             // R3: fill way 1, way 0 ages
        step(1, 0, 1);             // R8: hit way 0 wins over the fill
        step(0, 0, 1);             // R3: fill way 2
        step(0, 0, 1);             // R3: fill way 3, set now full
        step(0, 0, 0);
        step(1, 2, 0);             // R6: hit a middle-aged way
        step(1, 2, 0);             // R6: hit the youngest way
        step(0, 0, 1);             // R5: full fill evicts age 3
        step(0, 0, 1);             // R5
        step(1, 0, 0);             // R6
        for (int n = 0; n < 3000; n++) begin
            if (n % 700 == 0) begin
                @(negedge clk);
                rst_n = 1'b0; hit_i = 1'b0; fill_i = 1'b0;
                for (int i = 0; i < 4; i++) begin m_age[i] = 0; m_v[i] = 1'b0; end
                @(posedge clk);
                #1;
                compare_state("R1 reset");
                @(negedge clk);
                rst_n = 1'b1;
            end
            step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 2) != 0));
        end
        @(negedge clk);
        hit_i = 1'b0; fill_i = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule